// File: doc/BRIEF.md
# Static Memory Bank Access Controller

This block turns single-beat requests from an on-chip bus into read and write cycles on one external static memory bank, such as an SRAM, a ROM, an asynchronous NOR flash or a PSRAM. The memory shares the block's clock. On the memory side the block drives an active-low chip select, output enable and write enable, a registered address, write data with its own output enable, and it reads an active-low wait input. Every request gets exactly one response: a one-cycle ready pulse that carries the read data or an error flag.

Three 32-bit configuration words sit behind the same request port. A request with `req_cfg` high selects them, and `req_addr[1:0]` picks the word. These words set the cycle shape of the bank. Reads and writes can each run asynchronously, with an address phase and a data phase counted in clocks, or synchronously, with a fixed latency and then a single data beat. Writes can use their own timing word. Writes can also be refused as a whole. The wait input can stretch asynchronous cycles, synchronous cycles, both, or neither. A programmable timeout ends a stretched cycle with an error, so a stuck wait line cannot hang the bus.

Top module: `smc_bank`

## Requirements
- R1: A configuration access with `req_size` other than 2 (2 = 32-bit word, 1 = half, 0 = byte) returns `rsp_err`=1 and read data 0, and does not change any configuration word.
- R2: Configuration words read back their reset values after reset: control (word 0) 0x00000012, read timing (word 1) 0x00102021, write timing (word 2) 0x00000021. Bits outside control[5:0], read timing[23:0] and write timing[11:0] read as 0, and writing them has no effect.
- R3: Control bit 1 is write-allow. When it is 0, a memory write returns `rsp_err`=1, `mem_we_n` never goes low and memory content is unchanged.
- R4: An asynchronous read holds `mem_cs_n` and `mem_oe_n` low for A+D cycles. A is read timing[3:0]. D is read timing[11:4], and a value of 0 counts as 1. The value on `mem_din` at the end of the cycle is returned.
- R5: An asynchronous write holds `mem_cs_n` low for A+D cycles and `mem_we_n` low for the last D of them. `mem_doe` stays high, with data stable, while `mem_we_n` is low.
- R6: Control bit 2 selects the write timing word for asynchronous writes. When it is 0, writes use the read timing word.
- R7: Control bit 3 makes a low `mem_wait_n` at the end of an asynchronous data phase stretch the cycle until the wait input goes high. When bit 3 is 0, the wait input has no effect on asynchronous cycles.
- R8: Control bit 0 makes reads synchronous: `mem_cs_n` is low for L+1 cycles, where L is read timing[15:12]. With control bit 4 set, a low wait input after the latency stretches the cycle. With bit 4 clear, the wait input is ignored.
- R9: Control bit 5 makes writes synchronous, with the same L+1 shape and a single write-enable beat. When bit 5 is 0, writes are asynchronous even if bit 0 is set.
- R10: `rsp_ready` is high for exactly one cycle per accepted request, with all memory strobes already released. `rsp_err` is only high together with `rsp_ready`.
- R11: A stretched cycle whose wait input stays low ends after T+1 extra cycles, where T is read timing[23:16], and returns `rsp_err`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the block and the memory |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when the block is idle |
| req_cfg | input | 1 | 1 selects the configuration words, 0 the memory |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_addr | input | AW | Memory address; bits [1:0] select the configuration word |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error flag for the completing access |
| rsp_rdata | output | 32 | Read data for the completing access |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dout | output | 32 | Write data to memory |
| mem_doe | output | 1 | High while the block drives the data bus |
| mem_din | input | 32 | Read data from memory |
| mem_wait_n | input | 1 | Wait request from memory, active low |

## Verification
A wrong phase counter or a wrong timing-word choice shows up in the very next access as a chip-select or strobe window that is too long or too short. Because of this, every access is measured in cycles at the pins and compared with a length computed from the configuration words. A wrong mode bit, such as sync versus async or a wait that is honoured when it should not be, changes that length on the same access. A write-allow fault shows up as a write-enable pulse or as changed memory content. A fault in the response path shows up as a missing, doubled or mis-flagged ready pulse, within one cycle of the strobes releasing.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int DW     = 32;
  localparam int CTRL_W = 6;
  localparam int RTIM_W = 24;
  localparam int WTIM_W = 12;
  localparam int CNT_W  = 8;

  localparam int C_RD_SYNC    = 0;
  localparam int C_WR_ALLOW   = 1;
  localparam int C_WR_SPLIT   = 2;
  localparam int C_ASYNC_WAIT = 3;
  localparam int C_SYNC_WAIT  = 4;
  localparam int C_WR_SYNC    = 5;

  localparam logic [CTRL_W-1:0] CTRL_RST = 6'h12;
  localparam logic [RTIM_W-1:0] RTIM_RST = 24'h10_2021;
  localparam logic [WTIM_W-1:0] WTIM_RST = 12'h021;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_RTIM = 2'd1;
  localparam logic [1:0] SEL_WTIM = 2'd2;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_WAIT, S_RESP} seq_st_t;
endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [DW-1:0]     wdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic [RTIM_W-1:0] rtim,
  output logic [WTIM_W-1:0] wtim,
  output logic [DW-1:0]     rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= CTRL_RST;
      rtim <= RTIM_RST;
      wtim <= WTIM_RST;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL: ctrl <= wdata[CTRL_W-1:0];
        SEL_RTIM: rtim <= wdata[RTIM_W-1:0];
        SEL_WTIM: wtim <= wdata[WTIM_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rdata = DW'(ctrl);
      SEL_RTIM: rdata = DW'(rtim);
      SEL_WTIM: rdata = DW'(wtim);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/smc_timing_sel.sv
module smc_timing_sel
  import smc_pkg::*;
(
  input  logic              is_wr,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [RTIM_W-1:0] rtim,
  input  logic [WTIM_W-1:0] wtim,
  output logic [CNT_W-1:0]  a_len,
  output logic [CNT_W-1:0]  d_len,
  output logic [CNT_W-1:0]  tmo,
  output logic              honour,
  output logic              blocked
);
  logic       use_sync;
  logic [3:0] as_f;
  logic [7:0] ds_f;

  always_comb begin
    use_sync = is_wr ? ctrl[C_WR_SYNC] : ctrl[C_RD_SYNC];
    if (is_wr && ctrl[C_WR_SPLIT]) begin
      as_f = wtim[3:0];
      ds_f = wtim[11:4];
    end else begin
      as_f = rtim[3:0];
      ds_f = rtim[11:4];
    end
    if (use_sync) begin
      a_len  = CNT_W'(rtim[15:12]);
      d_len  = CNT_W'(1);
      honour = ctrl[C_SYNC_WAIT];
    end else begin
      a_len  = CNT_W'(as_f);
      d_len  = (ds_f == 8'd0) ? CNT_W'(1) : CNT_W'(ds_f);
      honour = ctrl[C_ASYNC_WAIT];
    end
    tmo     = CNT_W'(rtim[23:16]);
    blocked = is_wr && !ctrl[C_WR_ALLOW];
  end
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_go,
  input  logic             cfg_err,
  input  logic [DW-1:0]    cfg_rdata,
  input  logic             mem_go,
  input  logic             acc_wr,
  input  logic [AW-1:0]    acc_addr,
  input  logic [DW-1:0]    acc_wdata,
  input  logic [CNT_W-1:0] a_len,
  input  logic [CNT_W-1:0] d_len,
  input  logic [CNT_W-1:0] tmo,
  input  logic             honour,
  input  logic             blocked,
  output logic             idle,
  output logic             rsp_ready,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  output logic             mem_cs_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_doe,
  input  logic [DW-1:0]    mem_din,
  input  logic             mem_wait_n
);
  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dlen_q, tmo_q;
  logic             wr_q, honour_q;
  logic             fin, fin_err;

  assign idle = (st == S_IDLE);

  always_comb begin
    fin     = 1'b0;
    fin_err = 1'b0;
    if (st == S_DATA && cnt == '0 && !(honour_q && !mem_wait_n)) fin = 1'b1;
    if (st == S_WAIT && (mem_wait_n || cnt == '0)) begin
      fin     = 1'b1;
      fin_err = !mem_wait_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      dlen_q    <= '0;
      tmo_q     <= '0;
      wr_q      <= 1'b0;
      honour_q  <= 1'b0;
      rsp_ready <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_doe   <= 1'b0;
      mem_addr  <= '0;
      mem_dout  <= '0;
    end else begin
      rsp_ready <= 1'b0;
      rsp_err   <= 1'b0;
      if (fin) begin
        st        <= S_RESP;
        rsp_ready <= 1'b1;
        rsp_err   <= fin_err;
        rsp_rdata <= wr_q ? '0 : mem_din;
        mem_cs_n  <= 1'b1;
        mem_oe_n  <= 1'b1;
        mem_we_n  <= 1'b1;
        mem_doe   <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            if (cfg_go) begin
              st        <= S_RESP;
              rsp_ready <= 1'b1;
              rsp_err   <= cfg_err;
              rsp_rdata <= cfg_rdata;
            end else if (mem_go && blocked) begin
              st        <= S_RESP;
              rsp_ready <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
            end else if (mem_go) begin
              wr_q     <= acc_wr;
              honour_q <= honour;
              dlen_q   <= d_len;
              tmo_q    <= tmo;
              mem_addr <= acc_addr;
              mem_dout <= acc_wdata;
              mem_cs_n <= 1'b0;
              mem_oe_n <= acc_wr;
              mem_doe  <= acc_wr;
              if (a_len != '0) begin
                st  <= S_ADDR;
                cnt <= a_len - CNT_W'(1);
              end else begin
                st       <= S_DATA;
                cnt      <= d_len - CNT_W'(1);
                mem_we_n <= !acc_wr;
              end
            end
          end
          S_ADDR: begin
            if (cnt == '0) begin
              st       <= S_DATA;
              cnt      <= dlen_q - CNT_W'(1);
              mem_we_n <= !wr_q;
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
          S_DATA: begin
            if (cnt == '0) begin
              st  <= S_WAIT;
              cnt <= tmo_q;
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
          S_WAIT:  cnt <= cnt - CNT_W'(1);
          S_RESP:  st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/smc_bank.sv
module smc_bank
  import smc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_cfg,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_ready,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_doe,
  input  logic [DW-1:0] mem_din,
  input  logic          mem_wait_n
);
  logic              idle, cfg_go, cfg_err, cfg_we, mem_go;
  logic [CTRL_W-1:0] ctrl_q;
  logic [RTIM_W-1:0] rtim_q;
  logic [WTIM_W-1:0] wtim_q;
  logic [DW-1:0]     reg_rdata, cfg_rdata;
  logic [CNT_W-1:0]  a_len, d_len, tmo;
  logic              honour, blocked;

  assign cfg_go    = req_valid && idle && req_cfg;
  assign cfg_err   = (req_size != SIZE_WORD);
  assign cfg_we    = cfg_go && !cfg_err && req_write;
  assign cfg_rdata = (cfg_err || req_write) ? '0 : reg_rdata;
  assign mem_go    = req_valid && idle && !req_cfg;

  smc_cfg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .sel(req_addr[1:0]),
    .wdata(req_wdata), .ctrl(ctrl_q), .rtim(rtim_q), .wtim(wtim_q),
    .rdata(reg_rdata)
  );

  smc_timing_sel u_tsel (
    .is_wr(req_write), .ctrl(ctrl_q), .rtim(rtim_q), .wtim(wtim_q),
    .a_len(a_len), .d_len(d_len), .tmo(tmo), .honour(honour),
    .blocked(blocked)
  );

  smc_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .cfg_go(cfg_go), .cfg_err(cfg_err),
    .cfg_rdata(cfg_rdata), .mem_go(mem_go), .acc_wr(req_write),
    .acc_addr(req_addr), .acc_wdata(req_wdata), .a_len(a_len),
    .d_len(d_len), .tmo(tmo), .honour(honour), .blocked(blocked),
    .idle(idle), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_doe(mem_doe), .mem_din(mem_din), .mem_wait_n(mem_wait_n)
  );
endmodule

// File: rtl/smc_bank_chk.sv
module smc_bank_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rsp_ready,
  input logic          rsp_err,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_doe,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_dout,
  input logic          wr_allow
);
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |=> !rsp_ready); // R10
  AST_READY_RELEASED: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_doe)); // R10
  AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_ready); // R10
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n)); // R4
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n); // R5
  AST_WE_DRIVES_DATA: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_doe); // R5
  AST_WE_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$fell(mem_we_n)) |-> ($stable(mem_dout) && $stable(mem_addr))); // R5
  AST_NO_WE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> wr_allow); // R3
endmodule

bind smc_bank smc_bank_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
  .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_doe(mem_doe), .mem_addr(mem_addr), .mem_dout(mem_dout),
  .wr_allow(ctrl_q[smc_pkg::C_WR_ALLOW])
);

// File: tb/tb_smc_bank.sv
module tb_smc_bank;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_cfg = 1'b0, req_write = 1'b0;
  logic [1:0]    req_size = 2'd2;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_ready, rsp_err;
  logic [31:0]   rsp_rdata;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_doe;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_dout, mem_din;
  logic          mem_wait_n = 1'b1;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int cs_cnt = 0, oe_cnt = 0, we_cnt = 0, rdy_cnt = 0;
  logic [31:0] mem [16];
  logic [31:0] sh  [16];
  logic [31:0] c_ctrl, c_rtim, c_wtim;

  smc_bank #(.AW(AW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] init_val(int i);
    return {16'(i) ^ 16'hA5C3, ~16'(i)};
  endfunction

  assign mem_din = mem[mem_addr[3:0]];

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= init_val(i);
    end else if (!mem_we_n && mem_doe) begin
      mem[mem_addr[3:0]] <= mem_dout;
    end
  end

  always @(negedge clk) begin
    if (!mem_cs_n) cs_cnt++;
    if (!mem_oe_n) oe_cnt++;
    if (!mem_we_n) we_cnt++;
    if (rsp_ready) rdy_cnt++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_sync(bit wr, logic [31:0] c);
    return wr ? c[5] : c[0];
  endfunction

  function automatic int exp_dlen(bit wr, logic [31:0] c, logic [31:0] r,
                                  logic [31:0] w);
    logic [31:0] t;
    if (is_sync(wr, c)) return 1;
    t = (wr && c[2]) ? w : r;
    return (t[11:4] == 8'd0) ? 1 : int'(t[11:4]);
  endfunction

  function automatic int exp_len(bit wr, logic [31:0] c, logic [31:0] r,
                                 logic [31:0] w);
    logic [31:0] t;
    if (is_sync(wr, c)) return int'(r[15:12]) + 1;
    t = (wr && c[2]) ? w : r;
    return int'(t[3:0]) + exp_dlen(wr, c, r, w);
  endfunction

  task automatic wait_rsp();
    int g = 0;
    while (!rsp_ready && g < 2000) begin
      @(negedge clk);
      g++;
    end
    if (!rsp_ready) check(1'b0, "R10 no response", 32'd0, 32'd1);
  endtask

  task automatic cfg_acc(input bit wr, input logic [1:0] sel, input logic [1:0] sz,
                         input logic [31:0] d, output logic [31:0] rd,
                         output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_cfg = 1'b1; req_write = wr; req_size = sz;
    req_addr = AW'(sel); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp();
    rd = rsp_rdata; err = rsp_err;
    if (wr && !err) begin
      if (sel == 2'd0) c_ctrl = d & 32'h3F;
      if (sel == 2'd1) c_rtim = d & 32'hFF_FFFF;
      if (sel == 2'd2) c_wtim = d & 32'hFFF;
    end
  endtask

  task automatic set_cfg(input logic [1:0] sel, input logic [31:0] d);
    logic [31:0] rd; logic err;
    cfg_acc(1'b1, sel, 2'd2, d, rd, err);
  endtask

  task automatic mem_acc(input bit wr, input logic [3:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output logic err);
    @(negedge clk);
    cs_cnt = 0; oe_cnt = 0; we_cnt = 0; rdy_cnt = 0;
    req_valid = 1'b1; req_cfg = 1'b0; req_write = wr; req_size = 2'd2;
    req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp();
    rd = rsp_rdata; err = rsp_err;
    @(negedge clk);
    check(rdy_cnt == 1, "R10 ready pulse count", 32'(rdy_cnt), 32'd1);
  endtask

  task automatic exp_acc(input bit wr, input logic [3:0] a, input logic [31:0] d,
                         input string tag);
    logic [31:0] rd; logic err;
    int el, ed;
    el = exp_len(wr, c_ctrl, c_rtim, c_wtim);
    ed = exp_dlen(wr, c_ctrl, c_rtim, c_wtim);
    mem_acc(wr, a, d, rd, err);
    check(cs_cnt == el, {tag, " cs length"}, 32'(cs_cnt), 32'(el));
    check(err == 1'b0, {tag, " error flag"}, 32'(err), 32'd0);
    if (wr) begin
      sh[a] = d;
      check(we_cnt == ed, {tag, " we length"}, 32'(we_cnt), 32'(ed));
      check(mem[a] == d, {tag, " memory content"}, mem[a], d);
    end else begin
      check(oe_cnt == el, {tag, " oe length"}, 32'(oe_cnt), 32'(el));
      check(rd == sh[a], {tag, " read data"}, rd, sh[a]);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", 32'(cyc), 32'd150000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic err;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) sh[i] = init_val(i);
    c_ctrl = 32'h12; c_rtim = 32'h0010_2021; c_wtim = 32'h21;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rsp_ready == 1'b0, "R10 reset ready", 32'(rsp_ready), 32'd0);
    check({mem_cs_n, mem_oe_n, mem_we_n} == 3'b111, "R4 reset strobes",
          32'({mem_cs_n, mem_oe_n, mem_we_n}), 32'd7);

    // R2 reset values and reserved bits
    cfg_acc(1'b0, 2'd0, 2'd2, 0, rd, err);
    check(rd == 32'h12, "R2 ctrl reset", rd, 32'h12);
    cfg_acc(1'b0, 2'd1, 2'd2, 0, rd, err);
    check(rd == 32'h0010_2021, "R2 rtim reset", rd, 32'h0010_2021);
    cfg_acc(1'b0, 2'd2, 2'd2, 0, rd, err);
    check(rd == 32'h21, "R2 wtim reset", rd, 32'h21);
    set_cfg(2'd0, 32'hFFFF_FFFF);
    cfg_acc(1'b0, 2'd0, 2'd2, 0, rd, err);
    check(rd == 32'h3F, "R2 reserved ctrl bits", rd, 32'h3F);
    set_cfg(2'd0, 32'h12);

    // R1 narrow accesses
    cfg_acc(1'b1, 2'd0, 2'd1, 32'h0, rd, err);
    check(err == 1'b1, "R1 narrow write error", 32'(err), 32'd1);
    cfg_acc(1'b1, 2'd1, 2'd0, 32'h0, rd, err);
    check(err == 1'b1, "R1 byte write error", 32'(err), 32'd1);
    cfg_acc(1'b0, 2'd0, 2'd2, 0, rd, err);
    check(rd == 32'h12, "R1 ctrl unchanged", rd, 32'h12);
    cfg_acc(1'b0, 2'd1, 2'd2, 0, rd, err);
    check(rd == 32'h0010_2021, "R1 rtim unchanged", rd, 32'h0010_2021);
    cfg_acc(1'b0, 2'd0, 2'd1, 0, rd, err);
    check(err == 1'b1 && rd == 0, "R1 narrow read", rd, 32'd0);

    // R4 / R5 async read and write with default timing (3 cycles)
    exp_acc(1'b0, 4'd3, 0, "R4 async read");
    check(cs_cnt == 3, "R4 default length", 32'(cs_cnt), 32'd3);
    exp_acc(1'b1, 4'd5, 32'hDEAD_BEEF, "R5 async write");
    check(we_cnt == 2, "R5 default we length", 32'(we_cnt), 32'd2);
    exp_acc(1'b0, 4'd5, 0, "R5 read back");

    // R6 split write timing
    set_cfg(2'd2, 32'h052);
    exp_acc(1'b1, 4'd6, 32'h1234_5678, "R6 shared timing");
    check(cs_cnt == 3, "R6 shared length", 32'(cs_cnt), 32'd3);
    set_cfg(2'd0, 32'h16);
    exp_acc(1'b1, 4'd6, 32'h8765_4321, "R6 split timing");
    check(cs_cnt == 7 && we_cnt == 5, "R6 split length", 32'(cs_cnt), 32'd7);
    exp_acc(1'b0, 4'd6, 0, "R6 read unaffected");

    // R3 blocked write
    set_cfg(2'd0, 32'h10);
    mem_acc(1'b1, 4'd7, 32'hBAD0_BAD0, rd, err);
    check(err == 1'b1, "R3 blocked error", 32'(err), 32'd1);
    check(we_cnt == 0 && cs_cnt == 0, "R3 no strobe", 32'(we_cnt), 32'd0);
    check(mem[7] == sh[7], "R3 memory unchanged", mem[7], sh[7]);
    exp_acc(1'b0, 4'd7, 0, "R3 read allowed");

    // R7 async wait ignored then honoured
    set_cfg(2'd0, 32'h12);
    mem_wait_n = 1'b0;
    exp_acc(1'b0, 4'd2, 0, "R7 wait ignored");
    set_cfg(2'd0, 32'h1A);
    fork
      mem_acc(1'b0, 4'd2, 0, rd, err);
      begin
        wait (cs_cnt == 6);
        mem_wait_n = 1'b1;
      end
    join
    check(cs_cnt == 6, "R7 stretched length", 32'(cs_cnt), 32'd6);
    check(err == 1'b0 && rd == sh[2], "R7 stretched data", rd, sh[2]);

    // R11 timeout on async
    set_cfg(2'd1, 32'h0005_2021);
    mem_wait_n = 1'b0;
    mem_acc(1'b0, 4'd2, 0, rd, err);
    check(cs_cnt == 9, "R11 async timeout length", 32'(cs_cnt), 32'd9);
    check(err == 1'b1, "R11 async timeout error", 32'(err), 32'd1);

    // R8 synchronous reads
    set_cfg(2'd1, 32'h0005_3021);
    set_cfg(2'd0, 32'h13);
    mem_wait_n = 1'b1;
    exp_acc(1'b0, 4'd4, 0, "R8 sync read");
    check(cs_cnt == 4, "R8 sync length", 32'(cs_cnt), 32'd4);
    mem_wait_n = 1'b0;
    mem_acc(1'b0, 4'd4, 0, rd, err);
    check(cs_cnt == 10 && err == 1'b1, "R8 R11 sync wait timeout",
          32'(cs_cnt), 32'd10);
    set_cfg(2'd0, 32'h03);
    exp_acc(1'b0, 4'd4, 0, "R8 sync wait ignored");
    mem_wait_n = 1'b1;

    // R9 write mode
    set_cfg(2'd0, 32'h13);
    exp_acc(1'b1, 4'd8, 32'h0BAD_F00D, "R9 async write in sync-read mode");
    check(cs_cnt == 3, "R9 async write length", 32'(cs_cnt), 32'd3);
    set_cfg(2'd0, 32'h33);
    exp_acc(1'b1, 4'd9, 32'hCAFE_0001, "R9 sync write");
    check(cs_cnt == 4 && we_cnt == 1, "R9 sync write length", 32'(cs_cnt), 32'd4);

    // random mix (R4 R5 R6 R8 R9)
    for (int k = 0; k < 40; k++) begin
      logic [31:0] cv, rv, wv;
      cv = ($urandom & 32'h25) | 32'h02;
      rv = {8'd0, 8'd4, 4'($urandom % 4), 8'($urandom % 4), 4'($urandom % 4)};
      wv = {20'd0, 8'($urandom % 5), 4'($urandom % 3)};
      set_cfg(2'd0, cv);
      set_cfg(2'd1, rv);
      set_cfg(2'd2, wv);
      exp_acc(1'($urandom), 4'($urandom), $urandom, "R4 R5 R6 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule